// File: doc/BRIEF.md
# Row-latched dynamic memory with refresh scheduler

This block models a one-bit-wide dynamic memory arranged as a square cell array, together with the controller that drives it. It is meant for system models that need the access pattern and cycle cost of such a memory, including the cycles lost to refresh. `ADDR_W` sets the width of the shared address lines and gives 2^ADDR_W rows of 2^ADDR_W bits. The full-size part uses `ADDR_W = 11`, which is 2048 x 2048 = 4M x 1. The default is 5, a 32 x 32 array, so that elaboration stays small.

A client sends commands on a valid/ready channel, using one address field for every command. An OPEN command carries a row number. The controller decodes it, copies that whole row into the column latches, and keeps it as the open row. READ and WRITE commands then carry a column number, which selects one bit of the latches. A READ returns that bit on a valid/ready response channel. A WRITE changes the latch bit and writes the row back to the array in the same cycle. CLOSE releases the row.

A free-running timer raises a refresh request every `REF_INTERVAL` cycles. While a row is open the request waits. Once no row is open, the controller asserts `busy` and takes `REF_CYCLES` cycles to copy the row under the refresh pointer into the latches and write it back unchanged. It then advances the pointer, which wraps after the last row. With the defaults (400, 3), a refresh costs 4 of every 400 cycles, which is 1%.

Back-pressure rules:
- A command transfers on a rising edge where `cmd_valid` and `cmd_ready` are both high.
- `cmd_ready` is low while `busy` is high.
- `cmd_ready` is also low while a response is pending and `rsp_ready` is low.
- A pending response keeps `rsp_valid` and `rsp_data` unchanged until it is taken.

Top module: `dram_refresh_top`

## Requirements
- R1: After reset no row is open, `busy` is low, `cmd_ready` is high and `rsp_valid` is low.
- R2: `cmd_op` encodes OPEN = 0, READ = 1, WRITE = 2 and CLOSE = 3. An accepted OPEN opens the row given by `cmd_addr`. An accepted READ with a row open sets `rsp_valid` on the following cycle, with `rsp_data` equal to the stored bit at column `cmd_addr` of the open row.
- R3: An accepted WRITE with a row open stores `cmd_wdata` at column `cmd_addr` of that row. A later READ returns the new value, both before and after the row is closed and reopened.
- R4: A READ or WRITE accepted while no row is open produces no response and changes no stored bit.
- R5: An OPEN accepted while a row is open replaces the open row with the newly addressed row. Later READs return bits of the new row.
- R6: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and a low `cmd_ready` all hold.
- R7: With no row open, refreshes occur every `REF_INTERVAL` cycles, seen as rising edges of `busy` spaced exactly `REF_INTERVAL` cycles apart.
- R8: Each refresh started with no row open keeps `busy` high for `REF_CYCLES + 1` consecutive cycles, with `cmd_ready` low throughout. A refresh starts only from the state with no row open.
- R9: A refresh request raised while a row is open leaves `busy` low and `cmd_ready` high until the row is closed. `busy` is high in the cycle after the CLOSE is accepted.
- R10: Refresh rewrites each row with its own contents. The refresh pointer steps by one row per refresh and wraps after the last row, so stored data survives more than one full pass over every row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | Command code: OPEN 0, READ 1, WRITE 2, CLOSE 3 |
| cmd_addr | input | ADDR_W | Row number for OPEN, column number for READ and WRITE |
| cmd_wdata | input | 1 | Bit stored by WRITE |
| rsp_valid | output | 1 | Read response pending |
| rsp_ready | input | 1 | Client takes the response |
| rsp_data | output | 1 | Bit read |
| busy | output | 1 | Refresh pending with no row open, or refresh in progress |

## Verification
The assertions check on every cycle:
- a refresh only begins from the state with no row open and runs its full length;
- no refresh follows an open row;
- a held response stays stable;
- a pending refresh request is never lost;
- the refresh pointer moves by exactly one row per refresh;
- a command taken with no row open never produces a response.

Only the bench scenarios can show the data itself: that bits read match bits written across row switches and closes, and that refreshes repeat at the stated spacing. They also show that a deferred refresh follows the CLOSE in the next cycle, and that contents survive a full pass of the refresh pointer.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [1:0] {
    OP_OPEN  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_CLOSE = 2'd3
  } dram_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_REF  = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int ADDR_W = 5,
  localparam int NLINES = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_row,
  output logic [NLINES-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_row,
  input  logic [NLINES-1:0] wr_data
);
  logic [NLINES-1:0] row_view [NLINES];

  // one storage row per decoder output
  for (genvar g = 0; g < NLINES; g++) begin : g_row
    logic              sel;
    logic [NLINES-1:0] cells;
    assign sel = wr_en && (wr_row == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (sel) cells <= wr_data;
    end
    assign row_view[g] = cells;
  end

  assign rd_data = row_view[rd_row];
endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int ADDR_W       = 5,
  parameter int REF_INTERVAL = 400,
  localparam int CW = $clog2(REF_INTERVAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              done,
  output logic              pending,
  output logic [ADDR_W-1:0] ref_row
);
  logic [CW-1:0] tcnt_q;
  logic          tick;

  assign tick = (tcnt_q == CW'(REF_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt_q  <= '0;
      pending <= 1'b0;
      ref_row <= '0;
    end else begin
      tcnt_q <= tick ? '0 : tcnt_q + 1'b1;
      if (take) pending <= 1'b0;
      if (tick) pending <= 1'b1;
      if (done) ref_row <= ref_row + 1'b1;
    end
  end

  a_r7_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !take) |=> pending);
  a_r10_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(ref_row));
  a_r10_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (ref_row == ADDR_W'($past(ref_row) + 1'b1)));
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int REF_CYCLES = 3,
  localparam int NLINES = 1 << ADDR_W,
  localparam int RW     = $clog2(REF_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  dram_op_e          cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_data,
  output logic              busy,
  input  logic              ref_pending,
  input  logic [ADDR_W-1:0] ref_row,
  output logic              ref_take,
  output logic              ref_done,
  output logic [ADDR_W-1:0] arr_rd_row,
  input  logic [NLINES-1:0] arr_rd_data,
  output logic              arr_wr_en,
  output logic [ADDR_W-1:0] arr_wr_row,
  output logic [NLINES-1:0] arr_wr_data
);
  localparam logic [RW-1:0] LAST = RW'(REF_CYCLES - 1);

  ctrl_state_e       state_q;
  logic [ADDR_W-1:0] open_row_q;
  logic [NLINES-1:0] latch_q;
  logic [NLINES-1:0] latch_wr;
  logic [RW-1:0]     rcnt_q;
  logic              fire;
  logic              rsp_block;
  logic              in_ref;
  logic              ref_last;
  logic              col_write;

  assign in_ref    = (state_q == ST_REF);
  assign ref_last  = in_ref && (rcnt_q == LAST);
  assign ref_take  = (state_q == ST_IDLE) && ref_pending;
  assign busy      = in_ref || ref_take;
  assign rsp_block = rsp_valid && !rsp_ready;
  assign cmd_ready = !busy && !rsp_block;
  assign fire      = cmd_valid && cmd_ready;
  assign col_write = fire && (state_q == ST_OPEN) && (cmd_op == OP_WRITE);
  assign ref_done  = ref_last;

  always_comb begin
    latch_wr           = latch_q;
    latch_wr[cmd_addr] = cmd_wdata;
  end

  // shared array ports: refresh owns them while in_ref
  assign arr_rd_row  = in_ref ? ref_row : cmd_addr;
  assign arr_wr_en   = col_write || ref_last;
  assign arr_wr_row  = in_ref ? ref_row : open_row_q;
  assign arr_wr_data = in_ref ? latch_q : latch_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      open_row_q <= '0;
      latch_q    <= '0;
      rcnt_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= 1'b0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (ref_pending) begin
            state_q <= ST_REF;
            rcnt_q  <= '0;
          end else if (fire && cmd_op == OP_OPEN) begin
            state_q    <= ST_OPEN;
            open_row_q <= cmd_addr;
            latch_q    <= arr_rd_data;
          end
        end
        ST_OPEN: begin
          if (fire) begin
            case (cmd_op)
              OP_OPEN: begin
                open_row_q <= cmd_addr;
                latch_q    <= arr_rd_data;
              end
              OP_READ: begin
                rsp_valid <= 1'b1;
                rsp_data  <= latch_q[cmd_addr];
              end
              OP_WRITE: latch_q <= latch_wr;
              default:  state_q <= ST_IDLE;
            endcase
          end
        end
        default: begin
          rcnt_q <= rcnt_q + 1'b1;
          if (rcnt_q == '0) latch_q <= arr_rd_data;
          if (rcnt_q == LAST) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  a_r8_ref_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ref && rcnt_q == '0) |-> ($past(state_q) == ST_IDLE));
  a_r8_ref_full_len: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ref && rcnt_q != LAST) |=> (state_q == ST_REF));
  a_r9_no_ref_open: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OPEN) |=> (state_q != ST_REF));
  a_r6_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  a_r4_no_rsp_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && state_q != ST_OPEN) |=> !rsp_valid);
  a_r2_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && state_q == ST_OPEN && cmd_op == OP_READ) |=> rsp_valid);
endmodule

// File: rtl/dram_refresh_top.sv
module dram_refresh_top
  import dram_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int REF_INTERVAL = 400,
  parameter int REF_CYCLES   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_data,
  output logic              busy
);
  localparam int NLINES = 1 << ADDR_W;

  logic              ref_pending, ref_take, ref_done;
  logic [ADDR_W-1:0] ref_row, arr_rd_row, arr_wr_row;
  logic [NLINES-1:0] arr_rd_data, arr_wr_data;
  logic              arr_wr_en;

  dram_refresh_timer #(.ADDR_W(ADDR_W), .REF_INTERVAL(REF_INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .take(ref_take), .done(ref_done),
    .pending(ref_pending), .ref_row(ref_row)
  );

  dram_ctrl #(.ADDR_W(ADDR_W), .REF_CYCLES(REF_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(dram_op_e'(cmd_op)),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .busy(busy), .ref_pending(ref_pending), .ref_row(ref_row),
    .ref_take(ref_take), .ref_done(ref_done),
    .arr_rd_row(arr_rd_row), .arr_rd_data(arr_rd_data),
    .arr_wr_en(arr_wr_en), .arr_wr_row(arr_wr_row), .arr_wr_data(arr_wr_data)
  );

  dram_cell_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rd_row(arr_rd_row), .rd_data(arr_rd_data),
    .wr_en(arr_wr_en), .wr_row(arr_wr_row), .wr_data(arr_wr_data)
  );
endmodule

// File: tb/dram_refresh_top_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_top_tb_top;
  localparam int AW  = 5;
  localparam int NR  = 1 << AW;
  localparam int INT = 400;
  localparam int RC  = 3;
  localparam logic [1:0] C_OPEN = 2'd0, C_READ = 2'd1, C_WRITE = 2'd2, C_CLOSE = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic cmd_wdata = 1'b0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic rsp_data;
  logic busy;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [NR-1:0] shadow [NR];
  int cur_row = 0;

  always #2.5 clk = ~clk;

  dram_refresh_top #(.ADDR_W(AW), .REF_INTERVAL(INT), .REF_CYCLES(RC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .busy(busy)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input int addr, input logic wd);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_addr  = AW'(addr);
    cmd_wdata = wd;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_open(input int r);
    send(C_OPEN, r, 1'b0);
    cur_row = r;
  endtask

  task automatic do_write(input int c, input logic v);
    send(C_WRITE, c, v);
    shadow[cur_row][c] = v;
  endtask

  task automatic read_check(input int c, input string tag);
    send(C_READ, c, 1'b0);
    check(rsp_valid == 1'b1, {tag, " rsp_valid"}, int'(rsp_valid), 1);
    check(rsp_data == shadow[cur_row][c], {tag, " rsp_data"}, int'(rsp_data),
          int'(shadow[cur_row][c]));
  endtask

  task automatic wait_busy_rise(output int at);
    int n = 0;
    @(negedge clk);
    while (busy && n < 2 * INT) begin @(negedge clk); n++; end
    while (!busy && n < 4 * INT) begin @(negedge clk); n++; end
    at = cyc;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(cmd_ready == 1'b1, "R1 cmd_ready", int'(cmd_ready), 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
  endtask

  task automatic t_read_write;
    do_open(2);
    do_write(0, 1'b1);
    do_write(NR - 1, 1'b1);
    do_write(5, 1'b0);
    do_write(4, 1'b0);
    read_check(0, "R2 row2 col0");
    read_check(NR - 1, "R3 row2 top col");
    read_check(5, "R3 row2 col5");
    send(C_CLOSE, 0, 1'b0);
    do_open(7);
    do_write(NR - 1, 1'b0);
    do_write(0, 1'b0);
    read_check(NR - 1, "R3 row7 top col");
    do_open(2);
    read_check(NR - 1, "R5 reopen row2 top col");
    read_check(0, "R5 reopen row2 col0");
    send(C_CLOSE, 0, 1'b0);
    do_open(7);
    read_check(0, "R3 row7 after close");
    send(C_CLOSE, 0, 1'b0);
  endtask

  task automatic t_closed_ignored;
    send(C_WRITE, 4, 1'b1);
    check(rsp_valid == 1'b0, "R4 no rsp after closed write", int'(rsp_valid), 0);
    send(C_READ, 4, 1'b0);
    check(rsp_valid == 1'b0, "R4 no rsp after closed read", int'(rsp_valid), 0);
    do_open(2);
    read_check(4, "R4 row2 col4 unchanged");
    do_open(7);
    read_check(0, "R4 row7 col0 unchanged");
    send(C_CLOSE, 0, 1'b0);
  endtask

  task automatic t_backpressure;
    bit ok = 1'b1;
    do_open(2);
    @(negedge clk);
    rsp_ready = 1'b0;
    send(C_READ, NR - 1, 1'b0);
    check(rsp_valid && rsp_data == 1'b1, "R6 first response", int'(rsp_data), 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!(rsp_valid && rsp_data == 1'b1 && !cmd_ready)) ok = 1'b0;
    end
    check(ok, "R6 hold under back-pressure", int'(cmd_ready), 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R6 response taken", int'(rsp_valid), 0);
    send(C_CLOSE, 0, 1'b0);
  endtask

  task automatic t_refresh_period;
    int t1, t2, run;
    bit blocked = 1'b1;
    wait_busy_rise(t1);
    run = 0;
    while (busy && run < 20) begin
      if (cmd_ready) blocked = 1'b0;
      run++;
      @(negedge clk);
    end
    check(run == RC + 1, "R8 busy length", run, RC + 1);
    check(blocked, "R8 cmd_ready low during refresh", 1, 0);
    while (!busy && cyc - t1 < 2 * INT) @(negedge clk);
    t2 = cyc;
    check(t2 - t1 == INT, "R7 refresh spacing", t2 - t1, INT);
  endtask

  task automatic t_defer;
    bit quiet = 1'b1;
    while (busy) @(negedge clk);
    do_open(2);
    for (int i = 0; i < INT + 50; i++) begin
      @(negedge clk);
      if (busy || !cmd_ready) quiet = 1'b0;
    end
    check(quiet, "R9 no refresh while row open", int'(busy), 0);
    send(C_CLOSE, 0, 1'b0);
    check(busy == 1'b1, "R9 busy right after close", int'(busy), 1);
  endtask

  task automatic t_retention;
    int rises = 0;
    bit prev = 1'b0;
    for (int r = 0; r < NR; r++) begin
      do_open(r);
      do_write(r, 1'b1);
      do_write(r ^ (NR - 1), 1'b0);
      send(C_CLOSE, 0, 1'b0);
    end
    for (int i = 0; i < (NR + 2) * INT; i++) begin
      @(negedge clk);
      if (busy && !prev) rises++;
      prev = busy;
    end
    check(rises >= NR + 1, "R10 full refresh pass", rises, NR + 1);
    for (int r = 0; r < NR; r++) begin
      do_open(r);
      read_check(r, "R10 kept one");
      read_check(r ^ (NR - 1), "R10 kept zero");
      send(C_CLOSE, 0, 1'b0);
    end
    do_open(2);
    read_check(NR - 1, "R10 row2 old bit");
    send(C_CLOSE, 0, 1'b0);
  endtask

  initial begin
    for (int r = 0; r < NR; r++) shadow[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_write();
    t_closed_ignored();
    t_backpressure();
    t_refresh_period();
    t_defer();
    t_retention();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule